// File: doc/BRIEF.md
# PDM Microphone Output Emulator

This block stands in for the digital side of one pulse-density-modulated microphone. It is meant for testbenches and FPGA loopback rigs. Signed PCM samples come in through a valid/ready handshake. A fourth-order delta-sigma modulator turns them into a one-bit stream at one bit per bit-clock period. The bit is presented on the shared data line only during the half of the bit clock that belongs to the configured channel.

The block runs on a fast system clock and samples the bit clock as a data input through a synchronizer. It then acts on the edges it detects. The data line is modelled as a value plus an output enable, in place of a tristate pad. Two instances set to opposite channels can therefore share one wire without ever driving it at the same time. The channel-select pin is expected to be static and to change only while reset is held.

Top module: `pdm_mic_emu`

## Requirements
- R1: A synchronous reset clears every modulator integrator, the held sample and the sample counter. While reset is held and at its release, `pdm_oe_o` and `pdm_o` are 0 and `pcm_ready_o` is 1.
- R2: With `chan_sel_i` = 1 (left channel), a new bit is presented after each falling bit-clock edge. `pdm_oe_o` is high through the low half of the bit clock and low through the high half, so the block never drives after a rising edge. Each change follows the bit-clock edge by three system-clock cycles.
- R3: With `chan_sel_i` = 0 (right channel), the behaviour mirrors R2. A new bit follows each rising edge, `pdm_oe_o` is high through the high half and low through the low half.
- R4: Whenever `pdm_oe_o` is 0, `pdm_o` is 0.
- R5: The modulator advances exactly once per bit-clock period, on the channel's active edge. `pdm_o` holds its value for the whole half period in which it is driven.
- R6: A zero input gives a balanced stream. Over 512 driven bits the count of ones lies within 256 ± 16.
- R7: A DC input of +1/2 full scale gives a ones count of 384 ± 24 over 512 bits. An input of −1/2 full scale gives 128 ± 24.
- R8: When no new sample is offered, the last accepted sample stays in force at every later sample boundary, so the density from R7 persists.
- R9: `pcm_ready_o` is 1 exactly while the one-entry holding slot is empty. A sample is accepted on a cycle with `pcm_valid_i` and `pcm_ready_o` both high, and `pcm_ready_o` is 0 on the next cycle. A sample boundary occurs on the first active edge after reset and on every `OSR`-th active edge after that. At a boundary the held sample moves into the modulator and the slot empties.
- R10: Each integrator saturates at ±(2^(ACC_W−1)−1) and never wraps. A full-scale positive input (32767) gives at least 480 ones in 512 bits, and a full-scale negative input (−32768) gives at most 32 ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than the bit clock |
| rst_i | input | 1 | Synchronous reset, active high |
| bclk_i | input | 1 | Bit clock, sampled as data |
| chan_sel_i | input | 1 | Channel select: 1 = left, 0 = right |
| pcm_i | input | PCM_W | Signed PCM sample |
| pcm_valid_i | input | 1 | Sample offered |
| pcm_ready_o | output | 1 | Holding slot empty, sample will be accepted |
| pdm_o | output | 1 | Pulse-density data bit, 0 when not driven |
| pdm_oe_o | output | 1 | Output enable for the shared data line |

## Verification
A fault in the edge detection or the channel mapping shows at the enable pin within one bit-clock half period, about three system clocks after the offending edge. Corrupt integrator state, a wrong loop weight or a wrap instead of a clamp does not show in any single bit. It appears as a ones density that drifts from the input level over a few hundred bits, so density is judged over 512-bit windows with a settling lead-in. A holding-slot fault shows on the ready pin in the cycle after acceptance or after the first boundary.

// File: rtl/pdm_emu_pkg.sv
package pdm_emu_pkg;

  // modulator order
  localparam int LOOP_ORDER = 4;
  // fixed-point scale of loop weights (2^12)
  localparam int WEIGHT_SHIFT = 12;

  typedef enum logic {
    CH_RIGHT = 1'b0,
    CH_LEFT  = 1'b1
  } chan_e;

  // Weight of the k-th integrator (k = 1..4) in the quantizer sum.
  // Noise transfer ((z-1)/(z-p))^4 with p = 13/16 expands to
  // C(4,k) * (3/16)^k, scaled by 2^12.
  function automatic int loop_weight(input int k);
    int binom;
    int pw;
    binom = (k == 2) ? 6 : ((k == 1 || k == 3) ? 4 : 1);
    pw = 1;
    for (int i = 0; i < k; i++) pw = pw * 3;
    return (binom * pw * (1 << WEIGHT_SHIFT)) >> (4 * k);
  endfunction

endpackage

// File: rtl/pdm_edge_det.sv
module pdm_edge_det #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic bclk_i,
  input  logic left_i,
  output logic act_edge_o,
  output logic rel_edge_o,
  output logic lvl_o
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   rise, fall;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], bclk_i};
      prev_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign lvl_o = sync_q[SYNC_STAGES-1];
  assign rise  = lvl_o & ~prev_q;
  assign fall  = ~lvl_o & prev_q;

  // left drives after falling edges, right after rising edges
  assign act_edge_o = left_i ? fall : rise;
  assign rel_edge_o = left_i ? rise : fall;

endmodule

// File: rtl/pdm_sample_hold.sv
module pdm_sample_hold #(
  parameter int PCM_W = 16,
  parameter int OSR   = 64
) (
  input  logic                    clk_i,
  input  logic                    rst_i,
  input  logic signed [PCM_W-1:0] pcm_i,
  input  logic                    pcm_valid_i,
  output logic                    pcm_ready_o,
  input  logic                    tick_i,
  output logic signed [PCM_W-1:0] x_o
);

  localparam int CNT_W = (OSR > 1) ? $clog2(OSR) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(OSR - 1);

  logic [CNT_W-1:0]        cnt_q;
  logic                    full_q;
  logic signed [PCM_W-1:0] hold_q, x_q;
  logic                    boundary, accept;

  assign boundary    = tick_i && (cnt_q == '0);
  assign accept      = pcm_valid_i && !full_q;
  assign pcm_ready_o = !full_q;
  assign x_o         = x_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cnt_q  <= '0;
      full_q <= 1'b0;
      hold_q <= '0;
      x_q    <= '0;
    end else begin
      if (tick_i) cnt_q <= (cnt_q == CNT_LAST) ? '0 : cnt_q + 1'b1;
      if (boundary && full_q) x_q <= hold_q;
      if (accept) begin
        hold_q <= pcm_i;
        full_q <= 1'b1;
      end else if (boundary) begin
        full_q <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/pdm_dsm4.sv
module pdm_dsm4
  import pdm_emu_pkg::*;
#(
  parameter int PCM_W = 16,
  parameter int ACC_W = 32
) (
  input  logic                                clk_i,
  input  logic                                rst_i,
  input  logic                                step_i,
  input  logic signed [PCM_W-1:0]             x_i,
  output logic                                bit_o,
  output logic [LOOP_ORDER-1:0][ACC_W-1:0]    acc_o
);

  localparam int SUM_W = ACC_W + WEIGHT_SHIFT + 4;
  localparam logic signed [ACC_W:0]   ACC_MAX = {2'b00, {(ACC_W-1){1'b1}}};
  localparam logic signed [ACC_W:0]   ACC_MIN = -ACC_MAX;
  localparam logic signed [ACC_W-1:0] FB_MAG  = ACC_W'(1) << (PCM_W - 1);

  function automatic logic signed [ACC_W-1:0] sat_add(
    input logic signed [ACC_W-1:0] a,
    input logic signed [ACC_W-1:0] b
  );
    logic signed [ACC_W:0] s;
    s = {a[ACC_W-1], a} + {b[ACC_W-1], b};
    if (s > ACC_MAX) return ACC_MAX[ACC_W-1:0];
    if (s < ACC_MIN) return ACC_MIN[ACC_W-1:0];
    return s[ACC_W-1:0];
  endfunction

  logic [LOOP_ORDER-1:0][ACC_W-1:0] acc_q;
  logic signed [SUM_W-1:0]          wsum;
  logic                             dec;
  logic signed [ACC_W-1:0]          x_ext, err;
  logic                             bit_q;

  // quantizer: sign of weighted integrator sum
  always_comb begin
    wsum = '0;
    for (int k = 0; k < LOOP_ORDER; k++) begin
      wsum = wsum + $signed({{(SUM_W-ACC_W){acc_q[k][ACC_W-1]}}, acc_q[k]})
                  * $signed(SUM_W'(loop_weight(k + 1)));
    end
  end

  assign dec   = (wsum >= 0);
  assign x_ext = {{(ACC_W-PCM_W){x_i[PCM_W-1]}}, x_i};
  assign err   = dec ? (x_ext - FB_MAG) : (x_ext + FB_MAG);

  for (genvar k = 0; k < LOOP_ORDER; k++) begin : g_int
    logic signed [ACC_W-1:0] feed;
    if (k == 0) begin : g_first
      assign feed = err;
    end else begin : g_chain
      assign feed = $signed(acc_q[k-1]);
    end
    always_ff @(posedge clk_i) begin
      if (rst_i) acc_q[k] <= '0;
      else if (step_i) acc_q[k] <= sat_add($signed(acc_q[k]), feed);
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) bit_q <= 1'b0;
    else if (step_i) bit_q <= dec;
  end

  assign bit_o = bit_q;
  assign acc_o = acc_q;

endmodule

// File: rtl/pdm_mic_emu.sv
module pdm_mic_emu
  import pdm_emu_pkg::*;
#(
  parameter int PCM_W       = 16,
  parameter int OSR         = 64,
  parameter int ACC_W       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_i,
  input  logic                    bclk_i,
  input  logic                    chan_sel_i,
  input  logic signed [PCM_W-1:0] pcm_i,
  input  logic                    pcm_valid_i,
  output logic                    pcm_ready_o,
  output logic                    pdm_o,
  output logic                    pdm_oe_o
);

  logic                             act_edge, rel_edge, bclk_lvl;
  logic signed [PCM_W-1:0]          x_cur;
  logic                             mod_bit;
  logic [LOOP_ORDER-1:0][ACC_W-1:0] acc_bus;
  logic                             oe_q;
  chan_e                            chan;

  assign chan = chan_e'(chan_sel_i);

  pdm_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .bclk_i     (bclk_i),
    .left_i     (chan == CH_LEFT),
    .act_edge_o (act_edge),
    .rel_edge_o (rel_edge),
    .lvl_o      (bclk_lvl)
  );

  pdm_sample_hold #(.PCM_W(PCM_W), .OSR(OSR)) u_hold (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .pcm_i       (pcm_i),
    .pcm_valid_i (pcm_valid_i),
    .pcm_ready_o (pcm_ready_o),
    .tick_i      (act_edge),
    .x_o         (x_cur)
  );

  pdm_dsm4 #(.PCM_W(PCM_W), .ACC_W(ACC_W)) u_mod (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .step_i (act_edge),
    .x_i    (x_cur),
    .bit_o  (mod_bit),
    .acc_o  (acc_bus)
  );

  always_ff @(posedge clk_i) begin
    if (rst_i) oe_q <= 1'b0;
    else if (act_edge) oe_q <= 1'b1;
    else if (rel_edge) oe_q <= 1'b0;
  end

  assign pdm_oe_o = oe_q;
  assign pdm_o    = oe_q & mod_bit;

endmodule

// File: rtl/pdm_mic_emu_chk.sv
module pdm_mic_emu_chk #(
  parameter int ORDER = 4,
  parameter int ACC_W = 32
) (
  input logic                        clk_i,
  input logic                        rst_i,
  input logic                        chan_sel_i,
  input logic                        bclk_lvl_i,
  input logic                        pcm_valid_i,
  input logic                        pcm_ready_o,
  input logic                        pdm_o,
  input logic                        pdm_oe_o,
  input logic [ORDER-1:0][ACC_W-1:0] acc_i
);

  localparam logic signed [ACC_W-1:0] HALF_RANGE = {2'b01, {(ACC_W-2){1'b0}}};

  // R1
  reset_state_chk: assert property (@(posedge clk_i)
    rst_i |=> (!pdm_oe_o && !pdm_o && pcm_ready_o));

  // R2
  left_phase_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (chan_sel_i && $rose(pdm_oe_o)) |-> !bclk_lvl_i);

  // R3
  right_phase_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (!chan_sel_i && $rose(pdm_oe_o)) |-> bclk_lvl_i);

  // R5
  bit_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (pdm_oe_o && $past(pdm_oe_o)) |-> $stable(pdm_o));

  // R9
  ready_drop_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (pcm_valid_i && pcm_ready_o) |=> !pcm_ready_o);

  for (genvar k = 0; k < ORDER; k++) begin : g_acc
    // R10
    no_wrap_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      !(($signed($past(acc_i[k])) > HALF_RANGE) && ($signed(acc_i[k]) < -HALF_RANGE)));
  end

endmodule

bind pdm_mic_emu pdm_mic_emu_chk #(.ORDER(pdm_emu_pkg::LOOP_ORDER), .ACC_W(ACC_W)) u_chk (
  .clk_i       (clk_i),
  .rst_i       (rst_i),
  .chan_sel_i  (chan_sel_i),
  .bclk_lvl_i  (bclk_lvl),
  .pcm_valid_i (pcm_valid_i),
  .pcm_ready_o (pcm_ready_o),
  .pdm_o       (pdm_o),
  .pdm_oe_o    (pdm_oe_o),
  .acc_i       (acc_bus)
);

// File: tb/sim_pdm_mic_emu.sv
module sim_pdm_mic_emu;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               bclk = 1'b0;
  logic               sel = 1'b0;
  logic signed [15:0] pcm = '0;
  logic               valid = 1'b0;
  logic               ready, pdm, oe;

  int  n_tests = 0;
  int  n_fail  = 0;
  bit  exp_q[$];
  bit  mid = 1'b0, late = 1'b0, count_en = 1'b0;
  int  ones = 0, bits = 0;
  bit  mid_val = 1'b0, mid_oe = 1'b0;

  always #4 clk = ~clk;

  pdm_mic_emu u0 (
    .clk_i       (clk),
    .rst_i       (rst),
    .bclk_i      (bclk),
    .chan_sel_i  (sel),
    .pcm_i       (pcm),
    .pcm_valid_i (valid),
    .pcm_ready_o (ready),
    .pdm_o       (pdm),
    .pdm_oe_o    (oe)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: pops the expected enable level for each half period
  initial begin
    bit e;
    forever begin
      @(negedge clk); #1;
      if (mid) begin
        if (exp_q.size() == 0) chk(1'b0, "R2/R3 queue", 0, 1);
        else begin
          e = exp_q.pop_front();
          if (sel) chk(oe == e, "R2 left enable phase", int'(oe), int'(e));
          else     chk(oe == e, "R3 right enable phase", int'(oe), int'(e));
        end
        if (!oe) chk(pdm == 1'b0, "R4 released line low", int'(pdm), 0);
        mid_val = pdm;
        mid_oe  = oe;
        if (count_en && oe) begin
          bits++;
          ones += int'(pdm);
        end
      end
      if (late && mid_oe) chk(pdm == mid_val, "R5 bit held in half", int'(pdm), int'(mid_val));
    end
  end

  // driver: one bit-clock half period is 8 system clocks
  task automatic half();
    bclk = ~bclk;
    exp_q.push_back(sel ? ~bclk : bclk);
    repeat (4) @(negedge clk);
    mid = 1'b1;
    @(negedge clk);
    mid = 1'b0;
    @(negedge clk);
    late = 1'b1;
    @(negedge clk);
    late = 1'b0;
    @(negedge clk);
  endtask

  task automatic run_bits(input int n);
    for (int i = 0; i < n; i++) begin
      half();
      half();
    end
  endtask

  task automatic do_reset(input bit s);
    rst = 1'b1;
    valid = 1'b0;
    bclk = 1'b0;
    sel = s;
    exp_q.delete();
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk); #1;
    chk(oe == 1'b0, "R1 reset enable", int'(oe), 0);
    chk(pdm == 1'b0, "R1 reset data", int'(pdm), 0);
    chk(ready == 1'b1, "R1 reset ready", int'(ready), 1);
    @(negedge clk);
  endtask

  task automatic send(input logic signed [15:0] v);
    pcm = v;
    valid = 1'b1;
    @(negedge clk);
    valid = 1'b0;
    #1;
    chk(ready == 1'b0, "R9 ready drops after accept", int'(ready), 0);
    @(negedge clk);
  endtask

  task automatic measure(input string req, input int lo, input int hi, input int centre);
    ones = 0;
    bits = 0;
    count_en = 1'b1;
    run_bits(512);
    count_en = 1'b0;
    chk(bits == 512, {req, " driven bit count"}, bits, 512);
    chk(ones >= lo && ones <= hi, {req, " ones density"}, ones, centre);
  endtask

  task automatic scenario(input bit s, input logic signed [15:0] v);
    do_reset(s);
    send(v);
    run_bits(64);
    chk(ready == 1'b1, "R9 ready back after boundary", int'(ready), 1);
  endtask

  initial begin
    @(negedge clk);
    // R1, R6: zero input, right channel (R3)
    scenario(1'b0, 16'sd0);
    measure("R6 zero right", 240, 272, 256);
    // R6: zero input, left channel (R2)
    scenario(1'b1, 16'sd0);
    measure("R6 zero left", 240, 272, 256);
    // R7: +1/2 full scale
    scenario(1'b0, 16'sd16384);
    measure("R7 plus half", 360, 408, 384);
    // R7, R8: -1/2 full scale, then no further samples offered
    scenario(1'b1, -16'sd16384);
    measure("R7 minus half", 104, 152, 128);
    measure("R8 held sample", 104, 152, 128);
    // R10: full-scale inputs saturate without wrapping
    scenario(1'b0, 16'sd32767);
    measure("R10 full positive", 480, 512, 512);
    scenario(1'b1, -16'sd32768);
    measure("R10 full negative", 0, 32, 0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule